// File: doc/BRIEF.md
# 64-bit Integer Execute ALU with Word Operations

This block is the arithmetic and logic stage of a 64-bit integer pipeline. It takes a first operand, a register second operand, an unextended immediate, the instruction address and a decoded operation code, and produces a 64-bit result in the same cycle. The datapath covers add, subtract, the three bitwise operations, signed and unsigned set-less-than, left shift and right shift, and the two upper-immediate forms: load-upper and add-upper-to-PC.

A separate word-mode flag runs add, subtract and the shifts on 32-bit values. In word mode only the low half of each operand is read, and the 32-bit result is sign-extended to 64 bits. Encodings that have no defined meaning raise `rsvd_enc` and force the result to zero. A reserved encoding is a word shift by an immediate whose bit 5 is set, a word-mode request for an operation that has no word form, or an unused operation code.

The unit holds no state and has no state machine. Every output is a function of the present inputs.

Top module: `int_exec_alu`

## Requirements
- R1: `op_sel` encodes 0 add, 1 subtract, 2 left shift, 3 signed set-less-than, 4 unsigned set-less-than, 5 xor, 6 right shift, 7 or, 8 and, 9 load-upper, 10 add-upper-to-PC. `result` and `rsvd_enc` follow the inputs in the same cycle, and all-zero inputs give a zero result with `rsvd_enc` low.
- R2: With `word_mode` high on a word-capable operation (codes 0, 1, 2, 6), bits 63:32 of both operands have no effect, and bits 63:32 of `result` equal bit 31 of `result`.
- R3: Add and subtract wrap modulo 2^64, or modulo 2^32 in word mode. Overflow raises no flag and leaves `rsvd_enc` low.
- R4: A 64-bit shift reads only bits 5:0 of the second operand as its amount. A word shift reads only bits 4:0.
- R5: A right shift fills vacated bits with zeros when logical and with the sign bit when arithmetic. In word mode the sign bit is bit 31. In register form `alt_fn`=1 selects arithmetic; in immediate form `imm_raw[10]`=1 selects it.
- R6: With `use_imm` high, the second operand is `imm_raw[11:0]` sign-extended to 64 bits, and `imm_raw[19:12]` is ignored. A word add with a zero immediate returns the sign extension of `src_a[31:0]`.
- R7: Load-upper returns `imm_raw[19:0]` placed in bits 31:12, zeros in bits 11:0, sign-extended from bit 31.
- R8: Add-upper-to-PC returns `pc_in` plus the R7 value, modulo 2^64.
- R9: A word-mode immediate shift (code 2 or 6, `use_imm`=1) with `imm_raw[5]`=1 sets `rsvd_enc`=1 and `result`=0.
- R10: Word mode on codes 3, 4, 5, 7, 8, 9 or 10, or any code from 11 to 15, sets `rsvd_enc`=1 and `result`=0.
- R11: Set-less-than returns 1 or 0 in bit 0, with bits 63:1 zero. Code 3 compares as two's-complement values and code 4 as unsigned values.
- R12: Xor, or and and act bitwise on all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 64 | First operand |
| src_b | input | 64 | Register second operand |
| pc_in | input | 64 | Address of the current instruction |
| imm_raw | input | 20 | Immediate as extracted, not extended |
| op_sel | input | 4 | Operation code |
| word_mode | input | 1 | Selects the 32-bit word form |
| use_imm | input | 1 | Second operand taken from the immediate |
| alt_fn | input | 1 | Arithmetic right shift in register form |
| result | output | 64 | Operation result |
| rsvd_enc | output | 1 | Reserved encoding detected |

## Verification
Random operands are drawn from a mix of full-range words, values near the sign boundaries at bits 31 and 63, and small amounts. Upper halves are filled with junk so that word-mode results show whether those bits leak in. Shift amounts are placed above 31 and above 63, which separates correct masking from truncation at the wrong width. Negative and positive pairs show whether the signed and unsigned compares are confused. Directed immediates with bit 5 or bit 10 set show apart the reserved shift encoding from the arithmetic selector, and sign-boundary upper immediates show whether load-upper and add-upper-to-PC extend from bit 31.

// File: rtl/ixalu_pkg.sv
package ixalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_SLL    = 4'd2,
        OP_SLT    = 4'd3,
        OP_SLTU   = 4'd4,
        OP_XOR    = 4'd5,
        OP_SR     = 4'd6,
        OP_OR     = 4'd7,
        OP_AND    = 4'd8,
        OP_LDUP   = 4'd9,
        OP_ADDUPC = 4'd10
    } alu_op_e;

    localparam logic [3:0] OP_LAST = 4'd10;

    // Only these operations have a 32-bit word form.
    function automatic logic has_word_form(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_SLL) || (op == OP_SR);
    endfunction

    function automatic logic is_shift(input alu_op_e op);
        return (op == OP_SLL) || (op == OP_SR);
    endfunction

endpackage

// File: rtl/ixalu_operand.sv
module ixalu_operand #(
    parameter int XLEN    = 64,
    parameter int IMM_I_W = 12,
    parameter int IMM_U_W = 20
) (
    input  logic [XLEN-1:0]    reg_b,
    input  logic [IMM_U_W-1:0] imm_raw,
    input  logic               use_imm,
    output logic [XLEN-1:0]    opnd_b,
    output logic [XLEN-1:0]    upper_off
);
    localparam int I_FILL = XLEN - IMM_I_W;
    localparam int U_FILL = XLEN - IMM_U_W - IMM_I_W;

    logic [XLEN-1:0] imm_i_ext;

    always_comb begin
        imm_i_ext = {{I_FILL{imm_raw[IMM_I_W-1]}}, imm_raw[IMM_I_W-1:0]};
        upper_off = {{U_FILL{imm_raw[IMM_U_W-1]}}, imm_raw, {IMM_I_W{1'b0}}};
        opnd_b    = use_imm ? imm_i_ext : reg_b;
    end

    always_comb begin
        if (use_imm) begin
            AST_IMM_SIGN_FILL: assert (opnd_b[XLEN-1:IMM_I_W] == {I_FILL{imm_raw[IMM_I_W-1]}})
                else $error("immediate extension wrong"); // R6
        end
        AST_UPPER_LOW_ZERO: assert (upper_off[IMM_I_W-1:0] == '0)
            else $error("upper offset low bits set"); // R7
    end
endmodule

// File: rtl/ixalu_addcmp.sv
module ixalu_addcmp #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] add_a,
    input  logic [XLEN-1:0] add_b,
    input  logic            do_sub,
    input  logic [XLEN-1:0] cmp_a,
    input  logic [XLEN-1:0] cmp_b,
    output logic [XLEN-1:0] sum,
    output logic            lt_signed,
    output logic            lt_unsigned
);
    logic [XLEN-1:0] b_eff;

    always_comb begin
        b_eff       = do_sub ? ~add_b : add_b;
        sum         = add_a + b_eff + {{(XLEN-1){1'b0}}, do_sub};
        lt_unsigned = cmp_a < cmp_b;
        lt_signed   = $signed(cmp_a) < $signed(cmp_b);
    end

    always_comb begin
        if (cmp_a[XLEN-1] == cmp_b[XLEN-1]) begin
            AST_CMP_SAME_SIGN: assert (lt_signed == lt_unsigned)
                else $error("compares disagree on equal signs"); // R11
        end
        if (cmp_a[XLEN-1] != cmp_b[XLEN-1]) begin
            AST_CMP_DIFF_SIGN: assert (lt_signed != lt_unsigned)
                else $error("compares agree on opposite signs"); // R11
        end
    end
endmodule

// File: rtl/ixalu_shift.sv
module ixalu_shift #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic [XLEN-1:0]         value,
    input  logic [$clog2(XLEN)-1:0] amount,
    input  logic                    word,
    input  logic                    go_right,
    input  logic                    arith,
    output logic [XLEN-1:0]         shifted
);
    localparam int SHW  = $clog2(XLEN);
    localparam int WSHW = $clog2(WLEN);
    localparam int HI_W = XLEN - WLEN;

    logic [XLEN-1:0] src;
    logic [SHW-1:0]  eff;
    logic            fill;

    always_comb begin
        fill = arith & go_right & value[WLEN-1];
        if (word) begin
            src = {{HI_W{fill}}, value[WLEN-1:0]};
            eff = {{(SHW-WSHW){1'b0}}, amount[WSHW-1:0]};
        end else begin
            src = value;
            eff = amount;
        end
        if (!go_right)
            shifted = src << eff;
        else if (arith)
            shifted = $signed(src) >>> eff;
        else
            shifted = src >> eff;
    end

    always_comb begin
        if (word && amount[WSHW-1:0] == '0) begin
            AST_WORD_AMT_MASK: assert (shifted[WLEN-1:0] == value[WLEN-1:0])
                else $error("word shift used masked amount bits"); // R4
        end
        if (!word && go_right && !arith && amount != '0) begin
            AST_LOGIC_ZERO_FILL: assert (shifted[XLEN-1] == 1'b0)
                else $error("logical right shift filled ones"); // R5
        end
    end
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
    import ixalu_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int WLEN    = 32,
    parameter int IMM_I_W = 12,
    parameter int IMM_U_W = 20
) (
    input  logic [XLEN-1:0]    src_a,
    input  logic [XLEN-1:0]    src_b,
    input  logic [XLEN-1:0]    pc_in,
    input  logic [IMM_U_W-1:0] imm_raw,
    input  logic [3:0]         op_sel,
    input  logic               word_mode,
    input  logic               use_imm,
    input  logic               alt_fn,
    output logic [XLEN-1:0]    result,
    output logic               rsvd_enc
);
    localparam int SHW       = $clog2(XLEN);
    localparam int WSHW      = $clog2(WLEN);
    localparam int HI_W      = XLEN - WLEN;
    localparam int ARITH_BIT = IMM_I_W - 2;

    alu_op_e         op_e;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] upper_off;
    logic [XLEN-1:0] add_a;
    logic [XLEN-1:0] add_b;
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] shifted;
    logic            lt_s;
    logic            lt_u;
    logic            arith_sel;
    logic            known_op;
    logic [XLEN-1:0] raw_res;

    assign op_e = alu_op_e'(op_sel);

    ixalu_operand #(
        .XLEN(XLEN), .IMM_I_W(IMM_I_W), .IMM_U_W(IMM_U_W)
    ) u_operand (
        .reg_b     (src_b),
        .imm_raw   (imm_raw),
        .use_imm   (use_imm),
        .opnd_b    (opnd_b),
        .upper_off (upper_off)
    );

    always_comb begin
        add_a = (op_e == OP_ADDUPC) ? pc_in     : src_a;
        add_b = (op_e == OP_ADDUPC) ? upper_off : opnd_b;
    end

    ixalu_addcmp #(.XLEN(XLEN)) u_addcmp (
        .add_a       (add_a),
        .add_b       (add_b),
        .do_sub      (op_e == OP_SUB),
        .cmp_a       (src_a),
        .cmp_b       (opnd_b),
        .sum         (sum),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    assign arith_sel = use_imm ? imm_raw[ARITH_BIT] : alt_fn;

    ixalu_shift #(.XLEN(XLEN), .WLEN(WLEN)) u_shift (
        .value    (src_a),
        .amount   (opnd_b[SHW-1:0]),
        .word     (word_mode),
        .go_right (op_e == OP_SR),
        .arith    (arith_sel),
        .shifted  (shifted)
    );

    // Reserved-encoding detection
    always_comb begin
        known_op = (op_sel <= OP_LAST);
        rsvd_enc = !known_op
                 || (word_mode && !has_word_form(op_e))
                 || (word_mode && use_imm && is_shift(op_e) && imm_raw[WSHW]);
    end

    // Result selection
    always_comb begin
        unique case (op_e)
            OP_ADD, OP_SUB, OP_ADDUPC: raw_res = sum;
            OP_SLL, OP_SR:             raw_res = shifted;
            OP_SLT:                    raw_res = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU:                   raw_res = {{(XLEN-1){1'b0}}, lt_u};
            OP_XOR:                    raw_res = src_a ^ opnd_b;
            OP_OR:                     raw_res = src_a | opnd_b;
            OP_AND:                    raw_res = src_a & opnd_b;
            OP_LDUP:                   raw_res = upper_off;
            default:                   raw_res = '0;
        endcase
        if (rsvd_enc)
            result = '0;
        else if (word_mode)
            result = {{HI_W{raw_res[WLEN-1]}}, raw_res[WLEN-1:0]};
        else
            result = raw_res;
    end

    always_comb begin
        if (word_mode && !rsvd_enc) begin
            AST_WORD_SIGN_FILL: assert (result[XLEN-1:WLEN] == {HI_W{result[WLEN-1]}})
                else $error("word result not sign-extended"); // R2
        end
        if (rsvd_enc) begin
            AST_RSVD_QUIET: assert (result == '0)
                else $error("reserved encoding produced data"); // R9
        end
        if (word_mode && !has_word_form(op_e)) begin
            AST_WORD_ONLY_FORMS: assert (rsvd_enc)
                else $error("word mode on operation without word form"); // R10
        end
        if ((op_e == OP_SLT || op_e == OP_SLTU) && !word_mode) begin
            AST_CMP_NARROW: assert (result[XLEN-1:1] == '0)
                else $error("compare result wider than one bit"); // R11
        end
        if ((op_e == OP_ADD || op_e == OP_SUB) && known_op && !word_mode) begin
            AST_NO_OVERFLOW_FLAG: assert (!rsvd_enc)
                else $error("arithmetic overflow flagged"); // R3
        end
    end
endmodule

// File: tb/int_exec_alu_tb_top.sv
`timescale 1ns/1ps
module int_exec_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_a, src_b, pc_in;
    logic [19:0] imm_raw;
    logic [3:0]  op_sel;
    logic        word_mode, use_imm, alt_fn;
    logic [63:0] result;
    logic        rsvd_enc;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    int_exec_alu dut_i (
        .src_a(src_a), .src_b(src_b), .pc_in(pc_in), .imm_raw(imm_raw),
        .op_sel(op_sel), .word_mode(word_mode), .use_imm(use_imm), .alt_fn(alt_fn),
        .result(result), .rsvd_enc(rsvd_enc)
    );

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    // Returns {reserved, value}
    function automatic logic [64:0] model(input logic [3:0] op, input logic w, input logic ui,
                                          input logic [63:0] a, input logic [63:0] b,
                                          input logic [19:0] im, input logic alt,
                                          input logic [63:0] pc);
        logic [63:0] bb, up;
        logic        ar;
        logic [31:0] w32;
        bb = ui ? {{52{im[11]}}, im[11:0]} : b;
        up = {{32{im[19]}}, im, 12'h000};
        ar = ui ? im[10] : alt;
        if (op > 4'd10) return {1'b1, 64'd0};
        if (w && !(op == 4'd0 || op == 4'd1 || op == 4'd2 || op == 4'd6)) return {1'b1, 64'd0};
        if (w && ui && (op == 4'd2 || op == 4'd6) && im[5]) return {1'b1, 64'd0};
        if (w) begin
            case (op)
                4'd0:    w32 = a[31:0] + bb[31:0];
                4'd1:    w32 = a[31:0] - bb[31:0];
                4'd2:    w32 = a[31:0] << bb[4:0];
                default: w32 = ar ? 32'($signed(a[31:0]) >>> bb[4:0]) : (a[31:0] >> bb[4:0]);
            endcase
            return {1'b0, sx32(w32)};
        end
        case (op)
            4'd0:    return {1'b0, a + bb};
            4'd1:    return {1'b0, a - bb};
            4'd2:    return {1'b0, a << bb[5:0]};
            4'd3:    return {1'b0, 63'd0, ($signed(a) < $signed(bb))};
            4'd4:    return {1'b0, 63'd0, (a < bb)};
            4'd5:    return {1'b0, a ^ bb};
            4'd6:    return {1'b0, ar ? 64'($signed(a) >>> bb[5:0]) : (a >> bb[5:0])};
            4'd7:    return {1'b0, a | bb};
            4'd8:    return {1'b0, a & bb};
            4'd9:    return {1'b0, up};
            default: return {1'b0, pc + up};
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic w, input logic ui,
                                     input logic [19:0] im);
        if (op > 4'd10) return "R10";
        if (w && !(op == 4'd0 || op == 4'd1 || op == 4'd2 || op == 4'd6)) return "R10";
        if (w && ui && (op == 4'd2 || op == 4'd6) && im[5]) return "R9";
        if (w) return "R2";
        case (op)
            4'd0, 4'd1:       return "R3";
            4'd2:             return "R4";
            4'd6:             return "R5";
            4'd3, 4'd4:       return "R11";
            4'd5, 4'd7, 4'd8: return "R12";
            4'd9:             return "R7";
            default:          return "R8";
        endcase
    endfunction

    task automatic drive(input logic [3:0] op, input logic w, input logic ui,
                         input logic [63:0] a, input logic [63:0] b,
                         input logic [19:0] im, input logic alt, input logic [63:0] pc);
        @(negedge clk);
        op_sel = op; word_mode = w; use_imm = ui; src_a = a; src_b = b;
        imm_raw = im; alt_fn = alt; pc_in = pc;
        #1;
    endtask

    task automatic check(input string tag, input logic [63:0] exp_v, input logic exp_r);
        n_vec++;
        if (result !== exp_v || rsvd_enc !== exp_r) begin
            n_bad++;
            $display("FAIL %s: result=%h rsvd=%b expected result=%h rsvd=%b",
                     tag, result, rsvd_enc, exp_v, exp_r);
        end
    endtask

    task automatic run_model(input string tag, input logic [3:0] op, input logic w, input logic ui,
                             input logic [63:0] a, input logic [63:0] b,
                             input logic [19:0] im, input logic alt, input logic [63:0] pc);
        logic [64:0] m;
        drive(op, w, ui, a, b, im, alt, pc);
        m = model(op, w, ui, a, b, im, alt, pc);
        check(tag, m[63:0], m[64]);
    endtask

    function automatic logic [63:0] pick64();
        case ($urandom_range(0, 5))
            0:       return {$urandom, $urandom};
            1:       return {32'($urandom), 1'b1, 31'($urandom)};
            2:       return {1'b1, 63'($urandom)};
            3:       return 64'($urandom_range(0, 70));
            4:       return 64'h7FFF_FFFF_FFFF_FFFF - 64'($urandom_range(0, 3));
            default: return {$urandom, 32'h7FFF_FFFF};
        endcase
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        op_sel = 0; word_mode = 0; use_imm = 0; alt_fn = 0;
        src_a = 0; src_b = 0; pc_in = 0; imm_raw = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 64'd0, 1'b0); // reset-time idle inputs
        rst_n = 1'b1;

        // R1: same-cycle add
        drive(4'd0, 0, 0, 64'd5, 64'd7, 20'd0, 0, 64'd0);            check("R1", 64'd12, 1'b0);
        // R3: wrap without flag
        drive(4'd0, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0);   check("R3", 64'h8000_0000_0000_0000, 1'b0);
        drive(4'd1, 0, 0, 64'd0, 64'd1, 0, 0, 0);                     check("R3", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        // R2: word add ignores upper halves
        drive(4'd0, 1, 0, 64'hDEAD_BEEF_7FFF_FFFF, 64'h1234_5678_0000_0001, 0, 0, 0);
        check("R2", 64'hFFFF_FFFF_8000_0000, 1'b0);
        // R6: word add with zero immediate = sign extension
        drive(4'd0, 1, 1, 64'h1234_5678_8000_0000, 64'd99, 20'h00000, 0, 0);
        check("R6", 64'hFFFF_FFFF_8000_0000, 1'b0);
        drive(4'd0, 0, 1, 64'd10, 64'd0, 20'hAB_FFF, 0, 0);             check("R6", 64'd9, 1'b0);
        // R4: amount masking
        drive(4'd2, 0, 0, 64'd1, 64'd67, 0, 0, 0);                     check("R4", 64'd8, 1'b0);
        drive(4'd2, 1, 0, 64'hFFFF_0000_0000_0001, 64'd33, 0, 0, 0);   check("R4", 64'd2, 1'b0);
        // R5: fills and selector
        drive(4'd6, 0, 0, 64'h8000_0000_0000_0000, 64'd4, 0, 1, 0);    check("R5", 64'hF800_0000_0000_0000, 1'b0);
        drive(4'd6, 0, 0, 64'h8000_0000_0000_0000, 64'd4, 0, 0, 0);    check("R5", 64'h0800_0000_0000_0000, 1'b0);
        drive(4'd6, 1, 0, 64'h0000_0000_8000_0000, 64'd4, 0, 1, 0);    check("R5", 64'hFFFF_FFFF_F800_0000, 1'b0);
        drive(4'd6, 1, 1, 64'h0000_0000_8000_0000, 0, 20'h00404, 0, 0); check("R5", 64'hFFFF_FFFF_F800_0000, 1'b0);
        drive(4'd6, 1, 1, 64'h0000_0000_8000_0000, 0, 20'h00004, 1, 0); check("R5", 64'h0000_0000_0800_0000, 1'b0);
        // R7 / R8
        drive(4'd9, 0, 0, 0, 0, 20'h80000, 0, 0);                       check("R7", 64'hFFFF_FFFF_8000_0000, 1'b0);
        drive(4'd9, 0, 0, 0, 0, 20'h12345, 0, 0);                       check("R7", 64'h0000_0000_1234_5000, 1'b0);
        drive(4'd10, 0, 0, 0, 0, 20'hFFFFF, 0, 64'h1000);               check("R8", 64'd0, 1'b0);
        drive(4'd10, 0, 0, 0, 0, 20'h00001, 0, 64'hFFFF_FFFF_FFFF_F000); check("R8", 64'd0, 1'b0);
        // R9 / R10
        drive(4'd2, 1, 1, 64'd1, 0, 20'h00021, 0, 0);                   check("R9", 64'd0, 1'b1);
        drive(4'd6, 1, 1, 64'hFFFF, 0, 20'h00420, 0, 0);                check("R9", 64'd0, 1'b1);
        drive(4'd2, 0, 1, 64'd1, 0, 20'h00021, 0, 0);                   check("R9", 64'h2_0000_0000, 1'b0);
        drive(4'd5, 1, 0, 64'hF, 64'h1, 0, 0, 0);                       check("R10", 64'd0, 1'b1);
        drive(4'd13, 0, 0, 64'hF, 64'h1, 0, 0, 0);                      check("R10", 64'd0, 1'b1);
        // R11
        drive(4'd3, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0);     check("R11", 64'd1, 1'b0);
        drive(4'd4, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0);     check("R11", 64'd0, 1'b0);
        drive(4'd4, 0, 1, 64'd0, 0, 20'h00FFF, 0, 0);                   check("R11", 64'd1, 1'b0);
        // R12
        drive(4'd5, 0, 0, 64'hF0F0_0000_FFFF_0000, 64'hFF00_FF00_FF00_FF00, 0, 0, 0);
        check("R12", 64'h0FF0_FF00_00FF_FF00, 1'b0);
        drive(4'd7, 0, 0, 64'hF0F0_0000_FFFF_0000, 64'h0F00_0000_0000_00FF, 0, 0, 0);
        check("R12", 64'hFFF0_0000_FFFF_00FF, 1'b0);
        drive(4'd8, 0, 0, 64'hF0F0_0000_FFFF_0000, 64'hFF00_FF00_FF00_FF00, 0, 0, 0);
        check("R12", 64'hF000_0000_FF00_0000, 1'b0);

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            logic [3:0]  op;
            logic        w, ui, alt;
            logic [63:0] a, b, pc;
            logic [19:0] im;
            op  = ($urandom_range(0, 15) == 0) ? 4'($urandom_range(11, 15)) : 4'($urandom_range(0, 10));
            w   = ($urandom_range(0, 2) == 0);
            ui  = $urandom_range(0, 1) == 1;
            alt = $urandom_range(0, 1) == 1;
            a   = pick64();
            b   = pick64();
            pc  = pick64();
            im  = 20'($urandom);
            run_model(tag_of(op, w, ui, im), op, w, ui, a, b, im, alt, pc);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule